// File: doc/BRIEF.md
# Step-Driven Non-Restoring Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor, in unsigned or two's-complement signed form, and yields a 16-bit quotient and a 16-bit remainder. It uses the non-restoring method and settles one quotient bit per iteration. It has no free-running loop. Every advance is requested by an external per-cycle step strobe, which plays the part of a hardware repeat mechanism in the surrounding pipeline.

A full divide consists of exactly 19 steps:
- one setup step, which captures the operands and mode bits and forms the operand magnitudes;
- sixteen add/subtract iterations;
- one step that corrects a negative partial remainder;
- one step that applies the result signs.

All progress is held in registers that change only on a step. The caller can therefore stop issuing steps between any two of them, for any length of time, and resume later with the same final result. After the last step `done` stays high until the next step begins a fresh divide.

A zero divisor, or a quotient that does not fit in 16 bits in the selected mode, raises `error`. The quotient and remainder carry no meaning in that case.

Top module: `nrdiv_top`

## Requirements
- R1: While reset is asserted and until the first step after its release, `busy`, `done`, `error`, `quotient` and `remainder` are all 0.
- R2: A step taken while `busy` is low is the setup step. It samples `dividend`, `divisor`, `signed_mode` and `wide_mode`, and sets `busy`. After the 18th step `done` is still 0. After the 19th step `done` is 1 and `busy` is 0. Operand inputs that change after the setup step have no effect.
- R3: In any cycle where `step` is 0, `quotient`, `remainder`, `busy`, `done` and `error` keep their values. A pause of any length between steps leaves the final result unchanged.
- R4: With `signed_mode`=0, the quotient is the floor of dividend/divisor and the remainder is dividend − quotient·divisor. The remainder is always below the divisor.
- R5: With `wide_mode`=0, only `dividend[15:0]` is used. It is zero-extended when unsigned and sign-extended from bit 15 when signed, and bits 31:16 are ignored. With `wide_mode`=1, all 32 bits are used.
- R6: With `signed_mode`=1, operands are two's complement. The quotient rounds toward zero and is negative exactly when one operand is negative. The remainder has the sign of the dividend, or is 0.
- R7: A divisor of 0 sets `error` right after the setup step, and `error` is still 1 at `done`.
- R8: `error` is 1 at `done` when the true quotient lies outside 0..65535 (unsigned) or −32768..32767 (signed).
- R9: A step taken while `done` is 1 begins a new divide as its setup step. `done` falls and `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step | input | 1 | Advance strobe: one sequence step per cycle it is high |
| signed_mode | input | 1 | 1 = two's-complement operands, sampled at setup |
| wide_mode | input | 1 | 1 = 32-bit dividend, 0 = 16-bit dividend, sampled at setup |
| dividend | input | 32 | Dividend, sampled at setup |
| divisor | input | 16 | Divisor, sampled at setup |
| quotient | output | 16 | Quotient, valid when `done` is 1 and `error` is 0 |
| remainder | output | 16 | Remainder, valid when `done` is 1 and `error` is 0 |
| busy | output | 1 | A divide is in progress (between setup and the last step) |
| done | output | 1 | The last step has been taken; the result is held |
| error | output | 1 | Zero divisor or quotient overflow |

## Verification
Results count in steps, not in cycles.
- `busy` and the zero-divisor `error` are due at the first clock edge that samples a high `step` while idle.
- `done`, `quotient`, `remainder` and the overflow `error` are due at the edge that samples the 19th step.

The bench drives `step` and the operands on the falling edge and samples every output on a later falling edge. Each check therefore sees the registers exactly one rising edge after the step under test. Random pauses of zero to two idle cycles between steps are checked for unchanged outputs across each gap. Longer directed pauses confirm that a delayed run reaches the same result as an unbroken one.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

  // Action the next accepted step performs.
  typedef enum logic [1:0] {
    K_LOAD = 2'd0,
    K_ITER = 2'd1,
    K_CORR = 2'd2,
    K_FIX  = 2'd3
  } step_kind_t;

endpackage

// File: rtl/nrdiv_seq.sv
module nrdiv_seq
  import nrdiv_pkg::*;
#(
  parameter int unsigned ITERS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  output step_kind_t kind,
  output logic       busy,
  output logic       done
);

  localparam int unsigned LAST = ITERS + 3;
  localparam int unsigned CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] PH_LAST = CW'(LAST);
  localparam logic [CW-1:0] PH_ITER = CW'(ITERS);
  localparam logic [CW-1:0] PH_CORR = CW'(ITERS + 1);
  localparam logic [CW-1:0] PH_ONE  = CW'(1);

  logic [CW-1:0] ph_q, ph_d;

  always_comb begin
    if (ph_q == '0 || ph_q == PH_LAST) begin
      kind = K_LOAD;
    end else if (ph_q <= PH_ITER) begin
      kind = K_ITER;
    end else if (ph_q == PH_CORR) begin
      kind = K_CORR;
    end else begin
      kind = K_FIX;
    end
    ph_d = (kind == K_LOAD) ? PH_ONE : ph_q + PH_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (step) begin
      ph_q <= ph_d;
    end
  end

  assign busy = (ph_q != '0) && (ph_q != PH_LAST);
  assign done = (ph_q == PH_LAST);

endmodule

// File: rtl/nrdiv_prep.sv
module nrdiv_prep #(
  parameter int unsigned QW = 16
) (
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  input  logic            sgn,
  input  logic            wide,
  output logic [QW-1:0]   hi,
  output logic [QW-1:0]   lo,
  output logic [QW-1:0]   dmag,
  output logic            neg_q,
  output logic            neg_r,
  output logic            ovf
);

  localparam int unsigned DW = 2 * QW;

  logic          n_neg, d_neg;
  logic [DW-1:0] n_full, n_mag;

  always_comb begin
    n_neg  = sgn & (wide ? dividend[DW-1] : dividend[QW-1]);
    d_neg  = sgn & divisor[QW-1];
    n_full = wide ? dividend
                  : {{QW{sgn & dividend[QW-1]}}, dividend[QW-1:0]};
    n_mag  = n_neg ? (~n_full + DW'(1)) : n_full;
    dmag   = d_neg ? (~divisor + QW'(1)) : divisor;
    hi     = n_mag[DW-1:QW];
    lo     = n_mag[QW-1:0];
    neg_q  = n_neg ^ d_neg;
    neg_r  = n_neg;
    // Upper half not below divisor: quotient needs more than QW bits
    // (also covers a zero divisor).
    ovf    = (hi >= dmag);
  end

endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
  parameter int unsigned QW = 16
) (
  input  logic [QW+1:0] p_in,
  input  logic [QW-1:0] a_in,
  input  logic [QW-1:0] d_in,
  output logic [QW+1:0] p_out,
  output logic [QW-1:0] a_out
);

  localparam int unsigned PW = QW + 2;

  logic [PW-1:0] p_sh, d_ext, sum;

  always_comb begin
    p_sh  = {p_in[PW-2:0], a_in[QW-1]};
    d_ext = {2'b00, d_in};
    sum   = p_in[PW-1] ? (p_sh + d_ext) : (p_sh - d_ext);
    p_out = sum;
    a_out = {a_in[QW-2:0], ~sum[PW-1]};
  end

endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
  parameter int unsigned QW = 16
) (
  input  logic [QW-1:0] a_in,
  input  logic [QW-1:0] r_in,
  input  logic          neg_q,
  input  logic          neg_r,
  input  logic          sgn,
  output logic [QW-1:0] q_out,
  output logic [QW-1:0] r_out,
  output logic          ovf
);

  localparam logic [QW-1:0] HALF = {1'b1, {(QW-1){1'b0}}};

  always_comb begin
    q_out = neg_q ? (~a_in + QW'(1)) : a_in;
    r_out = neg_r ? (~r_in + QW'(1)) : r_in;
    ovf   = sgn & (neg_q ? (a_in > HALF) : (a_in >= HALF));
  end

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
  import nrdiv_pkg::*;
#(
  parameter int unsigned QW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            signed_mode,
  input  logic            wide_mode,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic [QW-1:0]   quotient,
  output logic [QW-1:0]   remainder,
  output logic            busy,
  output logic            done,
  output logic            error
);

  localparam int unsigned PW = QW + 2;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_core_n = rs_q[1];

  step_kind_t kind;

  nrdiv_seq #(.ITERS(QW)) u_seq (
    .clk   (clk),
    .rst_n (rst_core_n),
    .step  (step),
    .kind  (kind),
    .busy  (busy),
    .done  (done)
  );

  logic [QW-1:0] pr_hi, pr_lo, pr_dmag;
  logic          pr_negq, pr_negr, pr_ovf;

  nrdiv_prep #(.QW(QW)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .sgn      (signed_mode),
    .wide     (wide_mode),
    .hi       (pr_hi),
    .lo       (pr_lo),
    .dmag     (pr_dmag),
    .neg_q    (pr_negq),
    .neg_r    (pr_negr),
    .ovf      (pr_ovf)
  );

  // Architecturally visible state.
  logic [PW-1:0] p_q, p_d;
  logic [QW-1:0] a_q, a_d;
  logic [QW-1:0] d_q, d_d;
  logic          negq_q, negq_d, negr_q, negr_d, sgn_q, sgn_d, err_q, err_d;

  logic [PW-1:0] it_p;
  logic [QW-1:0] it_a;

  nrdiv_step #(.QW(QW)) u_step (
    .p_in  (p_q),
    .a_in  (a_q),
    .d_in  (d_q),
    .p_out (it_p),
    .a_out (it_a)
  );

  logic [QW-1:0] fx_q, fx_r;
  logic          fx_ovf;

  nrdiv_fix #(.QW(QW)) u_fix (
    .a_in  (a_q),
    .r_in  (p_q[QW-1:0]),
    .neg_q (negq_q),
    .neg_r (negr_q),
    .sgn   (sgn_q),
    .q_out (fx_q),
    .r_out (fx_r),
    .ovf   (fx_ovf)
  );

  always_comb begin
    p_d    = p_q;
    a_d    = a_q;
    d_d    = d_q;
    negq_d = negq_q;
    negr_d = negr_q;
    sgn_d  = sgn_q;
    err_d  = err_q;
    unique case (kind)
      K_LOAD: begin
        p_d    = {2'b00, pr_hi};
        a_d    = pr_lo;
        d_d    = pr_dmag;
        negq_d = pr_negq;
        negr_d = pr_negr;
        sgn_d  = signed_mode;
        err_d  = pr_ovf;
      end
      K_ITER: begin
        p_d = it_p;
        a_d = it_a;
      end
      K_CORR: begin
        if (p_q[PW-1]) begin
          p_d = p_q + {2'b00, d_q};
        end
      end
      K_FIX: begin
        a_d   = fx_q;
        p_d   = {2'b00, fx_r};
        err_d = err_q | fx_ovf;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      p_q    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      sgn_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (step) begin
      p_q    <= p_d;
      a_q    <= a_d;
      d_q    <= d_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
      sgn_q  <= sgn_d;
      err_q  <= err_d;
    end
  end

  assign quotient  = a_q;
  assign remainder = p_q[QW-1:0];
  assign error     = err_q;

endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
  parameter int unsigned QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          signed_mode,
  input logic [QW-1:0] divisor,
  input logic [QW-1:0] quotient,
  input logic [QW-1:0] remainder,
  input logic          busy,
  input logic          done,
  input logic          error
);

  logic          cap_sgn;
  logic [QW-1:0] cap_dvs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sgn <= 1'b0;
      cap_dvs <= '0;
    end else if (step && !busy) begin
      cap_sgn <= signed_mode;
      cap_dvs <= divisor;
    end
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(quotient) && $stable(remainder) && $stable(busy)
               && $stable(done) && $stable(error)));

  // R2
  done_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step));

  // R2
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !busy && divisor == '0) |=> error);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && step) |=> (!done && busy));

  // R4
  unsigned_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error && !cap_sgn) |-> (remainder < cap_dvs));

endmodule

bind nrdiv_top nrdiv_chk #(.QW(QW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .step        (step),
  .signed_mode (signed_mode),
  .divisor     (divisor),
  .quotient    (quotient),
  .remainder   (remainder),
  .busy        (busy),
  .done        (done),
  .error       (error)
);

// File: tb/tb_nrdiv_top.sv
module tb_nrdiv_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        signed_mode = 1'b0;
  logic        wide_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic [15:0] quotient, remainder;
  logic        busy, done, error;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nrdiv_top dut (
    .clk(clk), .rst_n(rst_n), .step(step), .signed_mode(signed_mode),
    .wide_mode(wide_mode), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .busy(busy),
    .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] n, input logic [15:0] d,
                                input bit sg, input bit wd, output bit e_err,
                                output logic [15:0] eq, output logic [15:0] er);
    longint nn, dd, q, r;
    if (sg) nn = wd ? longint'($signed(n)) : longint'($signed(n[15:0]));
    else    nn = wd ? longint'(n) : longint'(n[15:0]);
    dd = sg ? longint'($signed(d)) : longint'(d);
    eq = '0; er = '0;
    if (dd == 0) begin
      e_err = 1'b1;
    end else begin
      q = nn / dd;
      r = nn % dd;
      e_err = sg ? (q < -32768 || q > 32767) : (q > 65535);
      eq = q[15:0];
      er = r[15:0];
    end
  endfunction

  task automatic one_step();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  // Full divide; max_gap>0 inserts random pauses checked for stability.
  task automatic run_div(input logic [31:0] n, input logic [15:0] d,
                         input bit sg, input bit wd, input int max_gap,
                         input string req);
    bit e_err;
    logic [15:0] eq, er, hq, hr;
    model(n, d, sg, wd, e_err, eq, er);
    @(negedge clk);
    dividend = n; divisor = d; signed_mode = sg; wide_mode = wd;
    for (int k = 1; k <= 19; k++) begin
      int gap;
      one_step();
      if (k == 1) begin
        check(busy === 1'b1, "R2", "busy after setup", 32'(busy), 32'd1);
        // Scramble operands after setup: must have no effect (R2).
        dividend = $urandom; divisor = 16'($urandom);
        signed_mode = ~sg; wide_mode = ~wd;
      end
      if (k == 18)
        check(done === 1'b0 && busy === 1'b1, "R2", "done after 18 steps",
              32'(done), 32'd0);
      gap = (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0;
      if (gap > 0) begin
        hq = quotient; hr = remainder;
        repeat (gap) @(negedge clk);
        check(quotient === hq && remainder === hr, "R3", "hold during pause",
              {quotient, remainder}, {hq, hr});
      end
    end
    check(done === 1'b1 && busy === 1'b0, "R2", "done after 19 steps",
          {30'd0, done, busy}, 32'd2);
    check(error === e_err, req, "error flag", 32'(error), 32'(e_err));
    if (!e_err) begin
      check(quotient === eq, req, "quotient", 32'(quotient), 32'(eq));
      check(remainder === er, req, "remainder", 32'(remainder), 32'(er));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] hq, hr;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    check({busy, done, error} === 3'b000, "R1", "flags in reset",
          32'({busy, done, error}), 32'd0);
    check(quotient === 16'd0 && remainder === 16'd0, "R1", "data in reset",
          {quotient, remainder}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, error} === 3'b000, "R1", "flags after release",
          32'({busy, done, error}), 32'd0);

    // Directed cases.
    run_div(32'd100, 16'd7, 0, 0, 0, "R4");
    run_div(32'hFFFE_0001, 16'hFFFF, 0, 1, 0, "R4");
    run_div(32'h1234_5678, 16'hABCD, 0, 1, 0, "R4");
    run_div(32'hDEAD_0064, 16'd7, 0, 0, 0, "R5");        // upper bits ignored
    run_div(32'h0000_FFF9, 16'd2, 1, 0, 0, "R5");        // -7 from bit 15
    run_div(32'hFFFF_FFF9, 16'd2, 1, 1, 0, "R6");        // -7 / 2
    run_div(32'd7, 16'hFFFE, 1, 1, 0, "R6");             // 7 / -2
    run_div(32'hFFFF_FFF9, 16'hFFFE, 1, 1, 0, "R6");     // -7 / -2
    run_div(32'h0000_8000, 16'd1, 1, 0, 0, "R6");        // -32768 / 1
    run_div(32'hFFFF_8000, 16'hFFFF, 1, 1, 0, "R8");     // 32768 overflow
    run_div(32'h0001_0000, 16'd1, 0, 1, 0, "R8");
    run_div(32'h0000_8000, 16'hFFFF, 1, 0, 0, "R8");
    run_div(32'd1234, 16'd0, 0, 1, 0, "R7");
    run_div(32'd1234, 16'd0, 1, 0, 0, "R7");

    // R7: error visible right after setup with zero divisor.
    @(negedge clk) divisor = 16'd0; dividend = 32'd5;
    one_step();
    check(error === 1'b1, "R7", "error after setup", 32'(error), 32'd1);
    for (int k = 2; k <= 19; k++) one_step();

    // R3: long pause after done leaves result unchanged.
    run_div(32'd50000, 16'd123, 0, 0, 0, "R4");
    hq = quotient; hr = remainder;
    repeat (40) @(negedge clk);
    check(quotient === hq && remainder === hr && done === 1'b1, "R3",
          "hold after done", {quotient, remainder}, {hq, hr});

    // R9: step while done restarts.
    one_step();
    check(done === 1'b0 && busy === 1'b1, "R9", "restart from done",
          {30'd0, done, busy}, 32'd1);
    for (int k = 2; k <= 19; k++) one_step();
    check(done === 1'b1, "R9", "second run done", 32'(done), 32'd1);

    // R3: same divide with long pauses matches the unbroken result.
    @(negedge clk) dividend = 32'hFFF0_1234; divisor = 16'h7FF1;
    signed_mode = 1'b1; wide_mode = 1'b1;
    for (int k = 1; k <= 19; k++) begin
      one_step();
      repeat (k % 5 * 7) @(negedge clk);
    end
    begin
      bit e; logic [15:0] eq, er;
      model(32'hFFF0_1234, 16'h7FF1, 1, 1, e, eq, er);
      check(quotient === eq && remainder === er && error === e, "R3",
            "result after long pauses", {quotient, remainder}, {eq, er});
    end

    // Constrained random.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] n; logic [15:0] d; bit sg, wd;
      sg = 1'($urandom); wd = 1'($urandom);
      d = 16'($urandom);
      if ($urandom % 8 == 0) d = 16'($urandom % 4);
      n = $urandom;
      if (wd && !sg && d != 0) n[31:16] = 16'($urandom % d);
      if (wd && sg) n = 32'($signed(n) >>> ($urandom % 20));
      run_div(n, d, sg, wd, 2, sg ? "R6" : (wd ? "R4" : "R5"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule